// File: doc/BRIEF.md
# SRP VBUS Pulse Sequencer

This block times the two VBUS phases of an On-The-Go session request. When a start request arrives while the block is idle, it drives a VBUS-pulse enable for a programmed number of 1024-clock units. It then drives a VBUS-discharge enable for a second programmed number of units. A one-cycle done strobe closes the sequence. All counting runs on the PHY clock. A divide-by-2^PRESC_W prescaler produces the units, and a field-wide unit counter counts them.

Software programs the two durations through a small register port with one address bit. Reads return the selected field with its upper bits zero. The block copies both fields into working copies at the moment it accepts a start. Register writes made while a sequence is in flight therefore shape only the next sequence. An abort input drops the block back to idle from any state and silences every output in the same cycle.

Top module: `srp_pulse_seq`

## Requirements
- R1: After reset, the pulse field (address 0, PULSE_W=12 bits) reads 0x2C6 and the discharge field (address 1, DISCH_W=16 bits) reads 0xB8F. Reads return the field zero-extended, and written bits above the field width are dropped. vbus_pulse, vbus_disch and done are low.
- R2: A start accepted at a clock edge raises vbus_pulse from the next cycle. vbus_pulse stays high for exactly N·2^PRESC_W cycles, where N is the latched pulse field.
- R3: The cycle after the pulse phase ends, vbus_disch is high for exactly M·2^PRESC_W cycles, where M is the latched discharge field. vbus_pulse and vbus_disch are never high together.
- R4: done is high for exactly one cycle, immediately after the discharge phase. The block is then idle and all outputs are low.
- R5: A field of zero skips its phase. With both fields zero, done appears in the cycle right after the start is accepted.
- R6: start has no effect unless the block is idle. This includes start during the pulse, discharge and done cycles.
- R7: While abort is high, vbus_pulse, vbus_disch and done are low in that same cycle. The block is idle from the next cycle and gives no done for the aborted sequence.
- R8: The durations are latched when start is accepted. A write during a sequence, or one at the same edge as the accepted start, changes only the following sequence.
- R9: start and abort high together in idle start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | synchronous active-low reset |
| wr_en | input | 1 | write strobe for the selected field |
| reg_addr | input | 1 | field select: 0 pulse, 1 discharge |
| wr_data | input | 32 | write data, truncated to the field width |
| rd_data | output | 32 | selected field, zero-extended |
| start | input | 1 | request a sequence (taken only in idle) |
| abort | input | 1 | cancel any sequence immediately |
| vbus_pulse | output | 1 | VBUS pulsing enable |
| vbus_disch | output | 1 | VBUS discharge enable |
| done | output | 1 | one-cycle end-of-sequence strobe |

## Verification
A register write and the capture of the durations can fall on the same edge when software writes a field in the same cycle that start is accepted. The bench drives both in one cycle and expects the pulse phase to use the value held before the write. It then runs again without writing and expects the new value. Abort coinciding with start is provoked the same way and judged by outputs that stay low. Every run is checked cycle by cycle against an output sequence worked out arithmetically from the two field values.

// File: rtl/srp_pkg.sv
// Shared types for the SRP VBUS pulse sequencer.
package srp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_DISCH = 2'd2,
        ST_DONE  = 2'd3
    } srp_state_e;
endpackage

// File: rtl/srp_regs.sv
// Duration register pair with a one-bit address.
// Assumes a single-cycle write strobe. Reads are combinational, zero-extended.
module srp_regs #(
    parameter int DATA_W    = 32,
    parameter int PULSE_W   = 12,
    parameter int DISCH_W   = 16,
    parameter logic [PULSE_W-1:0] PULSE_RST = 12'h2C6,
    parameter logic [DISCH_W-1:0] DISCH_RST = 16'hB8F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               reg_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [PULSE_W-1:0] pulse_len,
    output logic [DISCH_W-1:0] disch_len,
    output logic [DATA_W-1:0]  rd_data
);
    // Field storage with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_len <= PULSE_RST;
            disch_len <= DISCH_RST;
        end else if (wr_en) begin
            if (reg_addr) disch_len <= wr_data[DISCH_W-1:0];
            else          pulse_len <= wr_data[PULSE_W-1:0];
        end
    end

    // Read mux, unused upper bits zero.
    always_comb begin
        rd_data = '0;
        if (reg_addr) rd_data[DISCH_W-1:0] = disch_len;
        else          rd_data[PULSE_W-1:0] = pulse_len;
    end
endmodule

// File: rtl/srp_phase_timer.sv
// Prescaler plus unit counter timing one phase of len * 2^PRESC_W cycles.
// Assumes len is nonzero while run is high. last marks the final cycle,
// and the counters restart at zero after it so back-to-back phases work.
module srp_phase_timer #(
    parameter int PRESC_W = 10,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [PRESC_W-1:0] presc;
    logic [CNT_W-1:0]   units;

    // Final cycle: prescaler at terminal value and last unit reached.
    assign last = run && (&presc) && (units == len - CNT_W'(1));

    // Count while running, clear when idle or at phase end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) begin
            presc <= '0;
            units <= '0;
        end else begin
            presc <= presc + PRESC_W'(1);
            if (&presc) units <= units + CNT_W'(1);
        end
    end
endmodule

// File: rtl/srp_seq_fsm.sv
// Sequence control: idle -> pulse -> discharge -> done, skipping zero-length
// phases. Latches durations when a start is accepted. Abort has top priority.
module srp_seq_fsm
    import srp_pkg::*;
#(
    parameter int PULSE_W = 12,
    parameter int DISCH_W = 16,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic [PULSE_W-1:0] pulse_len,
    input  logic [DISCH_W-1:0] disch_len,
    input  logic               phase_last,
    output logic               run,
    output logic [CNT_W-1:0]   phase_len,
    output logic               vbus_pulse,
    output logic               vbus_disch,
    output logic               done
);
    srp_state_e         state, state_nx;
    logic [PULSE_W-1:0] p_lat;
    logic [DISCH_W-1:0] d_lat;
    logic               accept;

    assign accept = (state == ST_IDLE) && start && !abort;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:
                if (accept) begin
                    if (pulse_len != '0)      state_nx = ST_PULSE;
                    else if (disch_len != '0) state_nx = ST_DISCH;
                    else                      state_nx = ST_DONE;
                end
            ST_PULSE:
                if (phase_last) state_nx = (d_lat != '0) ? ST_DISCH : ST_DONE;
            ST_DISCH:
                if (phase_last) state_nx = ST_DONE;
            ST_DONE:
                state_nx = ST_IDLE;
            default:
                state_nx = ST_IDLE;
        endcase
        if (abort) state_nx = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Duration capture at start acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_lat <= '0;
            d_lat <= '0;
        end else if (accept) begin
            p_lat <= pulse_len;
            d_lat <= disch_len;
        end
    end

    // Timer control and outputs, silenced by abort in the same cycle.
    always_comb begin
        run        = ((state == ST_PULSE) || (state == ST_DISCH)) && !abort;
        phase_len  = (state == ST_PULSE) ? CNT_W'(p_lat) : CNT_W'(d_lat);
        vbus_pulse = (state == ST_PULSE) && !abort;
        vbus_disch = (state == ST_DISCH) && !abort;
        done       = (state == ST_DONE)  && !abort;
    end
endmodule

// File: rtl/srp_pulse_seq.sv
// Top of the SRP VBUS pulse sequencer: register pair, sequence FSM and
// shared phase timer. Phase length = field * 2^PRESC_W PHY clocks.
module srp_pulse_seq #(
    parameter int DATA_W  = 32,
    parameter int PULSE_W = 12,
    parameter int DISCH_W = 16,
    parameter int PRESC_W = 10,
    parameter logic [PULSE_W-1:0] PULSE_RST = 12'h2C6,
    parameter logic [DISCH_W-1:0] DISCH_RST = 16'hB8F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              start,
    input  logic              abort,
    output logic              vbus_pulse,
    output logic              vbus_disch,
    output logic              done
);
    localparam int CNT_W = (PULSE_W > DISCH_W) ? PULSE_W : DISCH_W;

    logic [PULSE_W-1:0] pulse_len;
    logic [DISCH_W-1:0] disch_len;
    logic               run, phase_last;
    logic [CNT_W-1:0]   phase_len;

    srp_regs #(
        .DATA_W(DATA_W), .PULSE_W(PULSE_W), .DISCH_W(DISCH_W),
        .PULSE_RST(PULSE_RST), .DISCH_RST(DISCH_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .pulse_len(pulse_len), .disch_len(disch_len),
        .rd_data(rd_data)
    );

    srp_seq_fsm #(
        .PULSE_W(PULSE_W), .DISCH_W(DISCH_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .pulse_len(pulse_len), .disch_len(disch_len), .phase_last(phase_last),
        .run(run), .phase_len(phase_len), .vbus_pulse(vbus_pulse),
        .vbus_disch(vbus_disch), .done(done)
    );

    srp_phase_timer #(
        .PRESC_W(PRESC_W), .CNT_W(CNT_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .len(phase_len), .last(phase_last)
    );
endmodule

// File: rtl/srp_pulse_seq_chk.sv
// Port-level properties of the sequencer, bound into every instance.
module srp_pulse_seq_chk #(
    parameter int DATA_W  = 32,
    parameter int PULSE_W = 12,
    parameter int DISCH_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              start,
    input logic              abort,
    input logic              vbus_pulse,
    input logic              vbus_disch,
    input logic              done
);
    p_rd_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_addr) |-> (rd_data[DATA_W-1:PULSE_W] == '0));

    p_rd_upper_disch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr |-> (rd_data[DATA_W-1:DISCH_W] == '0));

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(vbus_pulse && vbus_disch));

    p_pulse_then_disch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vbus_pulse) && !abort && !$past(abort)) |-> (vbus_disch || done));

    p_disch_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vbus_disch) && !abort && !$past(abort)) |-> done);

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!vbus_pulse && !vbus_disch));

    p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!vbus_pulse && !vbus_disch && !done));

    p_abort_next_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!vbus_pulse && !vbus_disch && !done));

    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vbus_pulse && !abort) |=> (vbus_pulse || vbus_disch || done || abort));
endmodule

bind srp_pulse_seq srp_pulse_seq_chk #(
    .DATA_W(DATA_W), .PULSE_W(PULSE_W), .DISCH_W(DISCH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_data(rd_data),
    .start(start), .abort(abort), .vbus_pulse(vbus_pulse),
    .vbus_disch(vbus_disch), .done(done)
);

// File: tb/tb_srp_pulse_seq.sv
module tb_srp_pulse_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PRESC_W    = 2;
    localparam int U          = 1 << PRESC_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic        vbus_pulse, vbus_disch, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    srp_pulse_seq #(.PRESC_W(PRESC_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .start(start), .abort(abort),
        .vbus_pulse(vbus_pulse), .vbus_disch(vbus_disch), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {29'd0, done, vbus_disch, vbus_pulse};
    endfunction

    task automatic write_reg(bit a, int v);
        wr_en = 1'b1; reg_addr = a; wr_data = 32'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(bit a, int exp, string req);
        reg_addr = a;
        #1;
        check(rd_data == 32'(exp), req, int'(rd_data), exp);
    endtask

    // Start a sequence and compare every cycle with the ideal output code
    // (1 pulse, 2 discharge, 4 done, 0 idle). Optional extra start at index
    // inj, optional write at index widx, optional write along with the start.
    task automatic run_chk(string req, int n, int m, int inj, int widx,
                           bit wa, int wv, bit wstart);
        int total, bad, bad_k, bad_a, bad_e;
        total = n*U + m*U + 3;
        bad = 0; bad_k = 0; bad_a = 0; bad_e = 0;
        start = 1'b1;
        if (wstart) begin wr_en = 1'b1; reg_addr = wa; wr_data = 32'(wv); end
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        for (int k = 0; k < total; k++) begin
            int e;
            #1;
            if (k < n*U)              e = 1;
            else if (k < n*U + m*U)   e = 2;
            else if (k == n*U + m*U)  e = 4;
            else                      e = 0;
            if (outs() != e && bad == 0) begin
                bad_k = k; bad_a = outs(); bad_e = e;
            end
            if (outs() != e) bad++;
            start = (k == inj);
            if (k == widx && !wstart) begin
                wr_en = 1'b1; reg_addr = wa; wr_data = 32'(wv);
            end
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
        end
        if (bad != 0) $display("  at cycle %0d of run n=%0d m=%0d", bad_k, n, m);
        check(bad == 0, req, bad_a, bad_e);
    endtask

    task automatic abort_chk(int n, int m, int at);
        bit quiet;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (at) @(negedge clk);
        abort = 1'b1;
        #1;
        check(outs() == 0, "R7 same-cycle silence", outs(), 0);
        @(negedge clk);
        abort = 1'b0;
        quiet = 1'b1;
        for (int k = 0; k < (n + m) * U + 4; k++) begin
            #1;
            if (outs() != 0) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R7 idle after abort, no done", int'(quiet), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(outs() == 0, "R1 outputs low after reset", outs(), 0);
        read_chk(1'b0, 32'h2C6, "R1 pulse reset value");
        read_chk(1'b1, 32'hB8F, "R1 discharge reset value");
        @(negedge clk);

        // R2 R3 R4 with the reset defaults.
        run_chk("R2 R3 reset-default run", 32'h2C6, 32'hB8F, -1, -1, 1'b0, 0, 1'b0);

        // R1 field truncation.
        write_reg(1'b0, 32'hFFFF_FFFF);
        write_reg(1'b1, 32'hFFFF_FFFF);
        read_chk(1'b0, 32'hFFF, "R1 pulse width mask");
        read_chk(1'b1, 32'hFFFF, "R1 discharge width mask");
        @(negedge clk);

        // Sweep of both fields, zero skipping included (R2 R3 R4 R5).
        for (int n = 0; n < 5; n++) begin
            for (int m = 0; m < 5; m++) begin
                write_reg(1'b0, n);
                write_reg(1'b1, m);
                if (n == 0 || m == 0)
                    run_chk("R5 zero-field sweep", n, m, -1, -1, 1'b0, 0, 1'b0);
                else
                    run_chk("R2 R3 R4 sweep", n, m, -1, -1, 1'b0, 0, 1'b0);
            end
        end

        // R6: starts during pulse, discharge and done cycles are ignored.
        write_reg(1'b0, 3); write_reg(1'b1, 2);
        run_chk("R6 start in pulse", 3, 2, 2, -1, 1'b0, 0, 1'b0);
        run_chk("R6 start in discharge", 3, 2, 3*U + 1, -1, 1'b0, 0, 1'b0);
        run_chk("R6 start in done", 3, 2, 5*U, -1, 1'b0, 0, 1'b0);

        // R8: write during a run affects only the next run.
        run_chk("R8 write mid-run", 3, 2, -1, 1, 1'b0, 5, 1'b0);
        run_chk("R8 next run uses new value", 5, 2, -1, -1, 1'b0, 0, 1'b0);
        run_chk("R8 discharge write mid-run", 5, 2, -1, 2*U, 1'b1, 1, 1'b0);
        run_chk("R8 next discharge value", 5, 1, -1, -1, 1'b0, 0, 1'b0);

        // R8: write at the same edge as the accepted start.
        write_reg(1'b0, 1);
        run_chk("R8 write with start uses old", 1, 1, -1, -1, 1'b0, 3, 1'b1);
        run_chk("R8 write with start, next run", 3, 1, -1, -1, 1'b0, 0, 1'b0);

        // R7: abort in pulse, in discharge, in done.
        write_reg(1'b0, 3); write_reg(1'b1, 2);
        abort_chk(3, 2, 5);
        abort_chk(3, 2, 3*U + 2);
        abort_chk(3, 2, 5*U);
        run_chk("R7 start works after abort", 3, 2, -1, -1, 1'b0, 0, 1'b0);

        // R9: start and abort together in idle.
        start = 1'b1; abort = 1'b1;
        @(negedge clk);
        start = 1'b0; abort = 1'b0;
        quiet = 1'b1;
        for (int k = 0; k < 6*U; k++) begin
            #1;
            if (outs() != 0) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R9 abort beats start", int'(quiet), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule